// File: doc/BRIEF.md
# Programmable Counter Array Unit

A timing block built around one 16-bit counter that five compare/capture modules share. The counter advances on one of four selectable ticks: the system clock divided by 12, the system clock divided by 4, an overflow pulse from a neighbouring timer, or a falling edge on an external count pin. Each module works as an edge-triggered capture input, a software timer, a toggling output, an 8-bit PWM generator, or, on the last module only, a watchdog that requests a reset.

Software drives the unit through a simple byte-wide register bus. Writes take effect at the next clock edge and reads are combinational. Hardware sets the event flags and software clears them. One interrupt line collects every enabled flag.

Register map (byte addresses): 0x00 unit mode, 0x01 control/flags, 0x02 counter low byte, 0x03 counter high byte, 0x08+m compare/capture low byte of module m, 0x10+m compare/capture high byte of module m, 0x18+m mode byte of module m. Unit mode byte: bit 7 freeze-in-idle, bit 6 watchdog enable, bits 2:1 tick source, bit 0 overflow interrupt enable. Control byte: bit 7 overflow flag, bit 6 run, bits 4:0 module event flags. Module mode byte: bit 6 comparator enable, bit 5 capture on rising edge, bit 4 capture on falling edge, bit 3 match, bit 2 toggle, bit 1 PWM, bit 0 interrupt enable. Unused bits read 0.

Top module: `pca_unit`

## Requirements
- R1: The tick source field (unit mode bits 2:1) selects 0 = clock/12, 1 = clock/4, 2 = one count per cycle with `t0_ovf` high, 3 = one count per falling edge of `ext_cnt_in` (2-flop synchronised).
- R2: The counter holds while run (control bit 6) is 0. It also holds while `idle` is high if freeze-in-idle (unit mode bit 7) is set.
- R3: A counter step from 0xFFFF to 0x0000 sets the overflow flag (control bit 7). That flag drives `irq` only when unit mode bit 0 is set.
- R4: With capture-rise and/or capture-fall set, a matching edge on the synchronised `cex_in[m]` copies the counter value into the module's register pair and sets event flag m.
- R5: With comparator enable and match set, a counter step onto the value in the module's register pair sets event flag m.
- R6: With comparator enable, match and toggle set (and PWM clear), `cex_out[m]` inverts on each such match.
- R7: With PWM set, `cex_out[m]` is 0 while the counter low byte is below the module's low compare byte, and 1 otherwise.
- R8: With PWM set, each step of the counter low byte from 0xFF to 0x00 reloads the low compare byte from the high compare byte.
- R9: A write to a module's low compare byte clears its comparator enable. A write to its high compare byte sets it.
- R10: With watchdog enable set, a match on module 4 (comparator enable and match set) gives a one-cycle `wdog_rst` pulse in the cycle after the match. With watchdog enable clear, it gives no pulse.
- R11: Flags stay set until software writes 0 to them through the control byte. `irq` is the OR of each flag ANDed with its own enable.
- R12: After reset the counter, flags, run, all mode bytes, compare bytes, `cex_out`, `irq` and `wdog_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| t0_ovf | input | 1 | Neighbouring timer overflow pulse |
| ext_cnt_in | input | 1 | External count pin |
| idle | input | 1 | Device idle indication |
| cex_in | input | 5 | Module pin inputs |
| cex_out | output | 5 | Module pin outputs |
| irq | output | 1 | Shared interrupt |
| wdog_rst | output | 1 | Watchdog reset request |

## Verification
The bench builds the unit with its default parameters: five modules, divide ratios of 12 and 4, and a 16-bit counter. With the timer-overflow and external-pin tick sources the bench steps the counter one count at a time. This makes exact matches, toggles, PWM reloads and the watchdog pulse land on cycles it can predict. Preloading the counter near 0xFFFF puts the full-width overflow a few dozen cycles away.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_UMODE = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h01;
  localparam logic [ADDR_W-1:0] A_CNTL  = 5'h02;
  localparam logic [ADDR_W-1:0] A_CNTH  = 5'h03;
  localparam logic [ADDR_W-1:0] A_CMPL  = 5'h08;
  localparam logic [ADDR_W-1:0] A_CMPH  = 5'h10;
  localparam logic [ADDR_W-1:0] A_MMODE = 5'h18;

  typedef enum logic [1:0] {
    SRC_DIV_A = 2'd0,
    SRC_DIV_B = 2'd1,
    SRC_T0    = 2'd2,
    SRC_EXT   = 2'd3
  } tick_src_e;

  typedef struct packed {
    logic cmp_en;
    logic cap_pos;
    logic cap_neg;
    logic mat;
    logic tog;
    logic pwm;
    logic ie;
  } mod_cfg_t;
endpackage

// File: rtl/pca_pin_sync.sv
module pca_pin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur  = s2_q;
  assign prev = s3_q;
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_pkg::*;
#(
  parameter int DIV_A = 12,
  parameter int DIV_B = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tick_src_e        src,
  input  logic             run,
  input  logic             idle_stop,
  input  logic             idle,
  input  logic             t0_ovf,
  input  logic             ext_cur,
  input  logic             ext_prev,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             lo_wrap,
  output logic             ovf_evt
);
  localparam int PA_W = $clog2(DIV_A);
  localparam int PB_W = $clog2(DIV_B);
  localparam logic [PA_W-1:0] PA_END = PA_W'(DIV_A - 1);
  localparam logic [PB_W-1:0] PB_END = PB_W'(DIV_B - 1);

  logic [PA_W-1:0]  pa_q, pa_d;
  logic [PB_W-1:0]  pb_q, pb_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick, ext_fall, frozen;

  assign ext_fall = ext_prev & ~ext_cur;

  always_comb begin
    pa_d = (pa_q == PA_END) ? '0 : pa_q + 1'b1;
    pb_d = (pb_q == PB_END) ? '0 : pb_q + 1'b1;
    unique case (src)
      SRC_DIV_A: tick = (pa_q == PA_END);
      SRC_DIV_B: tick = (pb_q == PB_END);
      SRC_T0:    tick = t0_ovf;
      default:   tick = ext_fall;
    endcase
  end

  assign frozen  = idle_stop & idle;
  assign step    = run & ~frozen & tick & ~wr_lo & ~wr_hi;
  assign lo_wrap = step & (cnt_q[BYTE_W-1:0] == '1);
  assign ovf_evt = step & (cnt_q == '1);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo)      cnt_d[BYTE_W-1:0]     = wr_data;
    else if (wr_hi) cnt_d[CNT_W-1:BYTE_W] = wr_data;
    else if (step)  cnt_d                 = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      pb_q  <= '0;
      cnt_q <= '0;
    end else begin
      pa_q  <= pa_d;
      pb_q  <= pb_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  // R2
  hold_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_stop && idle && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == '0));
endmodule

// File: rtl/pca_module.sv
module pca_module
  import pca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              step,
  input  logic              lo_wrap,
  input  logic              pin_cur,
  input  logic              pin_prev,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_mode,
  input  logic [BYTE_W-1:0] wr_data,
  output mod_cfg_t          cfg_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              cex_o,
  output logic              evt_o,
  output logic              hit_o
);
  mod_cfg_t          cfg_q, cfg_d;
  logic [BYTE_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              tog_q, tog_d;
  logic              rise, fall, cap, eq, hit;
  logic [CNT_W-1:0]  cnt_nxt;

  assign rise    = pin_cur & ~pin_prev;
  assign fall    = ~pin_cur & pin_prev;
  assign cap     = (cfg_q.cap_pos & rise) | (cfg_q.cap_neg & fall);
  assign cnt_nxt = cnt + 1'b1;
  assign eq      = step & (cnt_nxt == {hi_q, lo_q});
  assign hit     = cfg_q.cmp_en & cfg_q.mat & eq;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_mode) cfg_d = mod_cfg_t'(wr_data[6:0]);
    if (wr_lo)   cfg_d.cmp_en = 1'b0;
    if (wr_hi)   cfg_d.cmp_en = 1'b1;

    lo_d = lo_q;
    if (wr_lo)                       lo_d = wr_data;
    else if (cap)                    lo_d = cnt[BYTE_W-1:0];
    else if (cfg_q.pwm && lo_wrap)   lo_d = hi_q;

    hi_d = hi_q;
    if (wr_hi)    hi_d = wr_data;
    else if (cap) hi_d = cnt[CNT_W-1:BYTE_W];

    tog_d = tog_q ^ (hit & cfg_q.tog);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      tog_q <= tog_d;
    end
  end

  assign cfg_o = cfg_q;
  assign lo_o  = lo_q;
  assign hi_o  = hi_q;
  assign cex_o = cfg_q.pwm ? (cnt[BYTE_W-1:0] >= lo_q) : tog_q;
  assign evt_o = cap | hit;
  assign hit_o = hit;

  // R9
  lo_write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> !cfg_q.cmp_en);
  // R9
  hi_write_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cfg_q.cmp_en);
  // R8
  pwm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.pwm && lo_wrap && !wr_lo && !cap) |=> (lo_q == $past(hi_q)));
  // R4
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !wr_lo && !wr_hi) |=> ({hi_q, lo_q} == $past(cnt)));
  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg_q.tog && !cfg_q.pwm && !wr_mode) |=> (cex_o != $past(cex_o)));
endmodule

// File: rtl/pca_unit.sv
module pca_unit
  import pca_pkg::*;
#(
  parameter int NUM_MOD = 5,
  parameter int DIV_A   = 12,
  parameter int DIV_B   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [4:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [4:0]         rd_addr,
  output logic [7:0]         rd_data,
  input  logic               t0_ovf,
  input  logic               ext_cnt_in,
  input  logic               idle,
  input  logic [NUM_MOD-1:0] cex_in,
  output logic [NUM_MOD-1:0] cex_out,
  output logic               irq,
  output logic               wdog_rst
);
  localparam int WD_IDX = NUM_MOD - 1;
  localparam int PAD_W  = BYTE_W - 2 - NUM_MOD;

  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rs2_q, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int = rs2_q;

  // write decode
  logic wr_umode, wr_ctrl, wr_cntl, wr_cnth;
  assign wr_umode = wr_en & (wr_addr == A_UMODE);
  assign wr_ctrl  = wr_en & (wr_addr == A_CTRL);
  assign wr_cntl  = wr_en & (wr_addr == A_CNTL);
  assign wr_cnth  = wr_en & (wr_addr == A_CNTH);

  // unit registers
  logic               istop_q, istop_d, wde_q, wde_d, ovie_q, ovie_d;
  logic [1:0]         src_q, src_d;
  logic               run_q, run_d, ovf_q, ovf_d, wd_q, wd_d;
  logic [NUM_MOD-1:0] evf_q, evf_d;

  // pin synchronisers
  logic [NUM_MOD:0] pin_cur, pin_prev;
  pca_pin_sync #(.W(NUM_MOD + 1)) u_sync (
    .clk  (clk),
    .rst_n(rst_int),
    .din  ({ext_cnt_in, cex_in}),
    .cur  (pin_cur),
    .prev (pin_prev)
  );

  // counter
  logic [CNT_W-1:0] cnt;
  logic             step, lo_wrap, ovf_evt;
  pca_timebase #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_tb (
    .clk      (clk),
    .rst_n    (rst_int),
    .src      (tick_src_e'(src_q)),
    .run      (run_q),
    .idle_stop(istop_q),
    .idle     (idle),
    .t0_ovf   (t0_ovf),
    .ext_cur  (pin_cur[NUM_MOD]),
    .ext_prev (pin_prev[NUM_MOD]),
    .wr_lo    (wr_cntl),
    .wr_hi    (wr_cnth),
    .wr_data  (wr_data),
    .cnt      (cnt),
    .step     (step),
    .lo_wrap  (lo_wrap),
    .ovf_evt  (ovf_evt)
  );

  // modules
  mod_cfg_t           m_cfg [NUM_MOD];
  logic [BYTE_W-1:0]  m_lo  [NUM_MOD];
  logic [BYTE_W-1:0]  m_hi  [NUM_MOD];
  logic [NUM_MOD-1:0] m_evt, m_hit, m_ie;

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
    localparam logic [ADDR_W-1:0] LA = A_CMPL  + ADDR_W'(g);
    localparam logic [ADDR_W-1:0] HA = A_CMPH  + ADDR_W'(g);
    localparam logic [ADDR_W-1:0] MA = A_MMODE + ADDR_W'(g);
    pca_module u_mod (
      .clk     (clk),
      .rst_n   (rst_int),
      .cnt     (cnt),
      .step    (step),
      .lo_wrap (lo_wrap),
      .pin_cur (pin_cur[g]),
      .pin_prev(pin_prev[g]),
      .wr_lo   (wr_en & (wr_addr == LA)),
      .wr_hi   (wr_en & (wr_addr == HA)),
      .wr_mode (wr_en & (wr_addr == MA)),
      .wr_data (wr_data),
      .cfg_o   (m_cfg[g]),
      .lo_o    (m_lo[g]),
      .hi_o    (m_hi[g]),
      .cex_o   (cex_out[g]),
      .evt_o   (m_evt[g]),
      .hit_o   (m_hit[g])
    );
    assign m_ie[g] = m_cfg[g].ie;
  end

  // next state of unit registers
  always_comb begin
    istop_d = istop_q;
    wde_d   = wde_q;
    src_d   = src_q;
    ovie_d  = ovie_q;
    if (wr_umode) begin
      istop_d = wr_data[7];
      wde_d   = wr_data[6];
      src_d   = wr_data[2:1];
      ovie_d  = wr_data[0];
    end
    run_d = run_q;
    ovf_d = ovf_q | ovf_evt;
    evf_d = evf_q | m_evt;
    if (wr_ctrl) begin
      run_d = wr_data[6];
      ovf_d = wr_data[7] | ovf_evt;
      evf_d = wr_data[NUM_MOD-1:0] | m_evt;
    end
    wd_d = wde_q & m_hit[WD_IDX];
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      istop_q <= 1'b0;
      wde_q   <= 1'b0;
      src_q   <= 2'd0;
      ovie_q  <= 1'b0;
      run_q   <= 1'b0;
      ovf_q   <= 1'b0;
      evf_q   <= '0;
      wd_q    <= 1'b0;
    end else begin
      istop_q <= istop_d;
      wde_q   <= wde_d;
      src_q   <= src_d;
      ovie_q  <= ovie_d;
      run_q   <= run_d;
      ovf_q   <= ovf_d;
      evf_q   <= evf_d;
      wd_q    <= wd_d;
    end
  end

  assign irq      = (ovf_q & ovie_q) | (|(evf_q & m_ie));
  assign wdog_rst = wd_q;

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_UMODE: rd_data = {istop_q, wde_q, 3'b000, src_q, ovie_q};
      A_CTRL:  rd_data = {ovf_q, run_q, {PAD_W{1'b0}}, evf_q};
      A_CNTL:  rd_data = cnt[BYTE_W-1:0];
      A_CNTH:  rd_data = cnt[CNT_W-1:BYTE_W];
      default: begin
        for (int m = 0; m < NUM_MOD; m++) begin
          if (rd_addr == A_CMPL  + ADDR_W'(m)) rd_data = m_lo[m];
          if (rd_addr == A_CMPH  + ADDR_W'(m)) rd_data = m_hi[m];
          if (rd_addr == A_MMODE + ADDR_W'(m)) rd_data = {1'b0, m_cfg[m]};
        end
      end
    endcase
  end

  // R3
  ovf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_int)
    ovf_evt |=> ovf_q);
  // R11
  ovf_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (ovf_q && !wr_ctrl) |=> ovf_q);
  // R11
  evt_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (!wr_ctrl) |=> ((evf_q & $past(evf_q)) == $past(evf_q)));
  // R10
  wdog_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_int)
    wdog_rst |-> $past(m_evt[WD_IDX]));
  // R10
  wdog_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (wdog_rst && !m_hit[WD_IDX]) |=> !wdog_rst);
endmodule

// File: tb/test_pca_unit.sv
module test_pca_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       t0_ovf, ext_cnt_in, idle;
  logic [4:0] cex_in, cex_out;
  logic       irq, wdog_rst;

  always #2 clk = ~clk;

  pca_unit i_pca_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .t0_ovf(t0_ovf), .ext_cnt_in(ext_cnt_in),
    .idle(idle), .cex_in(cex_in), .cex_out(cex_out), .irq(irq), .wdog_rst(wdog_rst)
  );

  int checks = 0;
  int fails  = 0;
  bit seen_wd = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        mr1, mr2;
  bit        istop, wde, ovie, run, ovf, wdq;
  int        src, p12, p4;
  bit  [4:0] evf;
  logic [15:0] cnt;
  logic [7:0]  lo [5];
  logic [7:0]  hi [5];
  logic [6:0]  md [5];
  bit  [4:0] tg;
  bit        e1, e2, e3;
  bit  [4:0] c1, c2, c3;

  task automatic mreset();
    istop = 0; wde = 0; ovie = 0; run = 0; ovf = 0; wdq = 0; src = 0; p12 = 0; p4 = 0;
    evf = 0; cnt = 0; tg = 0; e1 = 0; e2 = 0; e3 = 0; c1 = 0; c2 = 0; c3 = 0;
    for (int m = 0; m < 5; m++) begin lo[m] = 0; hi[m] = 0; md[m] = 0; end
  endtask

  task automatic mstep();
    bit tick, stp, wcnt, lowrap, ovfe, cap, hit, wlo, whi, wmd;
    bit [4:0] ev;
    logic [7:0] nlo [5];
    logic [7:0] nhi [5];
    logic [6:0] nmd [5];
    bit hit4;
    int a = wr_en ? int'(wr_addr) : -1;
    case (src)
      0: tick = (p12 == 11);
      1: tick = (p4 == 3);
      2: tick = t0_ovf;
      default: tick = e3 && !e2;
    endcase
    wcnt   = (a == 2) || (a == 3);
    stp    = run && !(istop && idle) && tick && !wcnt;
    lowrap = stp && (cnt[7:0] == 8'hFF);
    ovfe   = stp && (cnt == 16'hFFFF);
    ev = 0; hit4 = 0;
    for (int m = 0; m < 5; m++) begin
      cap = (md[m][5] && c2[m] && !c3[m]) || (md[m][4] && !c2[m] && c3[m]);
      hit = md[m][6] && md[m][3] && stp && (16'(cnt + 16'd1) == {hi[m], lo[m]});
      if (m == 4) hit4 = hit;
      ev[m] = cap || hit;
      wlo = (a == 8 + m); whi = (a == 16 + m); wmd = (a == 24 + m);
      nlo[m] = wlo ? wr_data : cap ? cnt[7:0] : (md[m][1] && lowrap) ? hi[m] : lo[m];
      nhi[m] = whi ? wr_data : cap ? cnt[15:8] : hi[m];
      nmd[m] = wmd ? wr_data[6:0] : md[m];
      if (wlo) nmd[m][6] = 0;
      if (whi) nmd[m][6] = 1;
      if (hit && md[m][2]) tg[m] = !tg[m];
    end
    for (int m = 0; m < 5; m++) begin lo[m] = nlo[m]; hi[m] = nhi[m]; md[m] = nmd[m]; end
    wdq = wde && hit4;
    if (a == 1) begin run = wr_data[6]; ovf = wr_data[7] || ovfe; evf = wr_data[4:0] | ev; end
    else begin ovf = ovf || ovfe; evf = evf | ev; end
    if (a == 0) begin istop = wr_data[7]; wde = wr_data[6]; src = int'(wr_data[2:1]); ovie = wr_data[0]; end
    if (a == 2) cnt[7:0] = wr_data;
    else if (a == 3) cnt[15:8] = wr_data;
    else if (stp) cnt = cnt + 16'd1;
    p12 = (p12 == 11) ? 0 : p12 + 1;
    p4  = (p4 == 3) ? 0 : p4 + 1;
    e3 = e2; e2 = e1; e1 = ext_cnt_in;
    c3 = c2; c2 = c1; c1 = cex_in;
  endtask

  function automatic logic [4:0] m_cex();
    logic [4:0] r;
    for (int m = 0; m < 5; m++) r[m] = md[m][1] ? (cnt[7:0] >= lo[m]) : tg[m];
    return r;
  endfunction

  function automatic logic m_irq();
    logic r = ovf && ovie;
    for (int m = 0; m < 5; m++) r = r | (evf[m] & md[m][0]);
    return r;
  endfunction

  function automatic logic [7:0] m_rd(input int a);
    if (a == 0) return {istop, wde, 3'b000, 2'(src), ovie};
    if (a == 1) return {ovf, run, 1'b0, evf};
    if (a == 2) return cnt[7:0];
    if (a == 3) return cnt[15:8];
    if (a >= 8 && a < 13)  return lo[a - 8];
    if (a >= 16 && a < 21) return hi[a - 16];
    if (a >= 24 && a < 29) return {1'b0, md[a - 24]};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin mr1 = 0; mr2 = 0; mreset(); end
    else begin
      if (!mr2) mreset(); else mstep();
      mr2 = mr1; mr1 = 1;
    end
  end

  // per-clock comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && mr2) begin
      chk("R6/R7 cex_out", int'(cex_out), int'(m_cex()));
      chk("R3/R11 irq", int'(irq), int'(m_irq()));
      chk("R10 wdog_rst", int'(wdog_rst), int'(wdq));
      chk("R1/R2/R4 rd_data", int'(rd_data), int'(m_rd(int'(rd_addr))));
    end
    if (wdog_rst) seen_wd = 1;
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_addr = 5'(a);
    @(posedge clk); #1; v = int'(rd_data);
  endtask

  task automatic t0_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); t0_ovf = 1;
      @(negedge clk); t0_ovf = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int v;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    t0_ovf = 0; ext_cnt_in = 0; idle = 0; cex_in = 0;
    idle_cycles(5);
    rst_n = 1;
    idle_cycles(5);

    // R12 reset state
    rd(1, v); chk("R12 ctrl", v, 0);
    rd(2, v); chk("R12 cnt", v, 0);
    rd(26, v); chk("R12 module mode", v, 0);
    chk("R12 irq", int'(irq), 0);
    chk("R12 cex_out", int'(cex_out), 0);
    chk("R12 wdog_rst", int'(wdog_rst), 0);

    // R1 clock/12
    wr(1, 8'h40);
    idle_cycles(120);
    rd(2, v); chk("R1 div12", int'(v >= 9 && v <= 11), 1);
    // R1 clock/4
    wr(0, 8'h02); wr(2, 0);
    idle_cycles(40);
    rd(2, v); chk("R1 div4", int'(v >= 9 && v <= 11), 1);
    // R1 timer overflow ticks
    wr(0, 8'h04); wr(2, 0);
    t0_pulse(7);
    rd(2, v); chk("R1 t0 ticks", v, 7);
    // R1 external falling edges
    wr(0, 8'h06); wr(2, 0);
    for (int i = 0; i < 5; i++) begin
      ext_cnt_in = 1; idle_cycles(4);
      ext_cnt_in = 0; idle_cycles(4);
    end
    idle_cycles(4);
    rd(2, v); chk("R1 ext edges", v, 5);

    // R2 run cleared
    wr(1, 8'h00); wr(0, 8'h04); wr(2, 8'h20);
    t0_pulse(4);
    rd(2, v); chk("R2 stopped", v, 8'h20);
    // R2 freeze in idle
    wr(0, 8'h84); wr(1, 8'h40);
    idle = 1; t0_pulse(3);
    rd(2, v); chk("R2 idle frozen", v, 8'h20);
    idle = 0; t0_pulse(2);
    rd(2, v); chk("R2 idle released", v, 8'h22);

    // R3 overflow
    wr(0, 8'h03); wr(2, 8'hF0); wr(3, 8'hFF);
    idle_cycles(100);
    rd(1, v); chk("R3 ovf flag", (v >> 7) & 1, 1);
    chk("R3 irq", int'(irq), 1);
    // R11 sticky then cleared by software
    idle_cycles(20);
    chk("R11 still set", int'(irq), 1);
    wr(1, 8'h40);
    rd(1, v); chk("R11 cleared", (v >> 7) & 1, 0);
    chk("R11 irq low", int'(irq), 0);

    // R4 capture
    wr(24, 8'h21); wr(25, 8'h10); wr(26, 8'h30);
    @(negedge clk); cex_in[2:0] = 3'b111;
    idle_cycles(6);
    rd(1, v); chk("R4 rise flags", v & 8'h07, 8'h05);
    @(negedge clk); cex_in[2:0] = 3'b000;
    idle_cycles(6);
    rd(1, v); chk("R4 fall flags", v & 8'h07, 8'h07);
    rd(16, v); rd(9, v);
    wr(1, 8'h40);
    wr(24, 0); wr(25, 0); wr(26, 0);

    // R9 / R5 compare
    wr(0, 8'h04); wr(2, 0); wr(3, 0);
    wr(27, 8'h49);
    wr(11, 8'h05);
    rd(27, v); chk("R9 low write disarms", v, 8'h09);
    wr(19, 8'h00);
    rd(27, v); chk("R9 high write arms", v, 8'h49);
    t0_pulse(4);
    rd(1, v); chk("R5 no early match", v & 8'h08, 0);
    t0_pulse(1);
    rd(1, v); chk("R5 match flag", v & 8'h08, 8'h08);
    chk("R5 irq", int'(irq), 1);
    wr(1, 8'h40);

    // R6 toggle output
    wr(25, 8'h4C); wr(9, 8'h08); wr(17, 8'h00);
    wr(2, 0); wr(3, 0);
    t0_pulse(8);
    chk("R6 toggle high", int'(cex_out[1]), 1);
    wr(2, 8'h07);
    t0_pulse(1);
    chk("R6 toggle low", int'(cex_out[1]), 0);

    // R7 / R8 PWM
    wr(26, 8'h42); wr(10, 8'h40); wr(18, 8'h80);
    wr(2, 8'h10);
    chk("R7 below threshold", int'(cex_out[2]), 0);
    wr(2, 8'h50);
    chk("R7 above threshold", int'(cex_out[2]), 1);
    wr(2, 8'hFF);
    t0_pulse(1);
    rd(10, v); chk("R8 reload", v, 8'h80);
    chk("R7 after reload", int'(cex_out[2]), 0);
    wr(2, 8'h90);
    chk("R7 above new threshold", int'(cex_out[2]), 1);

    // R10 watchdog
    wr(28, 8'h48); wr(12, 8'h03); wr(20, 8'h00);
    wr(2, 0); wr(3, 0);
    seen_wd = 0;
    t0_pulse(3); idle_cycles(2);
    chk("R10 disabled no pulse", int'(seen_wd), 0);
    wr(0, 8'h44); wr(2, 0);
    seen_wd = 0;
    t0_pulse(3); idle_cycles(2);
    chk("R10 enabled pulse", int'(seen_wd), 1);
    chk("R10 pulse ended", int'(wdog_rst), 0);

    idle_cycles(4);
    summary();
  end
endmodule